// File: doc/BRIEF.md
# Secure Scan Mode Guard

This block wraps a small set of ordinary data registers for scan test while keeping secret and control-sequence registers out of the test path. In functional mode every ordinary register loads its own data word under its own load strobe. In test mode the ordinary registers link into one serial shift path from `scan_in` to `scan_out`. A key register and an FSM-state register sit outside that path. They cannot be loaded from `scan_in`, and they cannot be observed at `scan_out`.

Every change of `scan_en`, rising or falling, produces a one-cycle clear. During that cycle the block raises `clr_pulse`, suppresses shifting and loading, and forces `scan_out` low. At the clock edge that ends the cycle, every ordinary, key and state bit becomes zero. Secrets loaded in functional mode therefore never reach test mode. A pattern shifted in during test cannot survive into functional operation.

The chain runs from bit 0 of register 0 up to the top bit of register 0. It then continues through bit 0 of register 1, and so on up to the top bit of the last register. The register word bus packs register i at bits `[i*DATA_W +: DATA_W]`.

Top module: `sscan_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, every register output reads zero. `scan_out` and `clr_pulse` are also low while `scan_en` is low.
- R2: When `scan_en` is low and no clear is active, ordinary register i takes `func_data[i*DATA_W +: DATA_W]` at the clock edge if `func_load[i]` is 1. Otherwise it keeps its value.
- R3: When `scan_en` is high and no clear is active, each clock edge moves every chain bit one place toward `scan_out`. Bit 0 of register 0 takes `scan_in`. `scan_out` shows the top bit of the last register. A bit presented at `scan_in` therefore appears at `scan_out` exactly NUM_REGS*DATA_W shift cycles later.
- R4: `clr_pulse` is high in a cycle exactly when `scan_en` differs from its value at the previous clock edge. The previous value is taken as 0 after reset. This holds for changes in both directions.
- R5: At the clock edge that ends a cycle with `clr_pulse` high, all ordinary, key and state register bits become zero. Loads and shifting are ignored at that edge.
- R6: `scan_out` is 0 whenever `scan_en` is low or `clr_pulse` is high.
- R7: The key and state registers load `key_data`/`state_next` under `key_load`/`state_load` only when `scan_en` is low and no clear is active. During shift cycles they hold, whatever the load strobes or `scan_in` do.
- R8: Key and state contents never reach `scan_out`. Over any run of shift cycles, `scan_out` shows only bits that entered at `scan_in`, or zeros left by the entry clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low functional reset |
| scan_en | input | 1 | 1 selects test shifting, 0 selects functional mode |
| scan_in | input | 1 | Serial test data entering the chain |
| func_data | input | NUM_REGS*DATA_W | Functional load words, register i at `[i*DATA_W +: DATA_W]` |
| func_load | input | NUM_REGS | Per-register functional load strobe |
| key_data | input | KEY_W | Key load value |
| key_load | input | 1 | Key load strobe (functional mode only) |
| state_next | input | ST_W | FSM state load value |
| state_load | input | 1 | FSM state load strobe (functional mode only) |
| scan_out | output | 1 | Serial test data leaving the chain |
| reg_q | output | NUM_REGS*DATA_W | Ordinary register contents |
| key_q | output | KEY_W | Key register contents |
| state_q | output | ST_W | FSM state register contents |
| clr_pulse | output | 1 | One-cycle clear strobe on each mode change |

## Verification
The bench measures the chain length with a single marker bit. A design that left out a segment or placed one twice would report the marker early or late. It also drops `scan_en` while the chain holds a pattern. A design that cleared only on entry to test would then leak test data into functional registers. It asserts the key and state load strobes, with data, during shifting. A design that gated those loads only by the clear would change the key there. Finally, it fills the key with ones before entering test and shifts a long run of zeros. Any path from key bits to `scan_out`, or a missing entry clear, would show up as a stray 1.

// File: rtl/sg_pkg.sv
package sg_pkg;

   // Per-cycle operation chosen by the mode tracker.
   typedef enum logic [1:0] {
      OP_FUNC  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_CLEAR = 2'd2
   } sg_op_e;

   function automatic int unsigned sg_chain_len(input int unsigned n_regs,
                                                input int unsigned width);
      return n_regs * width;
   endfunction

endpackage

// File: rtl/sg_mode_track.sv
module sg_mode_track
   import sg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   scan_en,
   output sg_op_e op,
   output logic   clr
);

   logic en_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_prev_q <= 1'b0;
      else        en_prev_q <= scan_en;
   end

   always_comb begin
      clr = scan_en ^ en_prev_q;
      if (clr)          op = OP_CLEAR;
      else if (scan_en) op = OP_SHIFT;
      else              op = OP_FUNC;
   end

endmodule

// File: rtl/sg_chain_seg.sv
module sg_chain_seg
   import sg_pkg::*;
#(
   parameter int unsigned W = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  sg_op_e       op,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         sin,
   output logic [W-1:0] q,
   output logic         sout
);

   logic [W-1:0] shifted;

   generate
      if (W == 1) begin : g_one_bit
         assign shifted = sin;
      end else begin : g_multi_bit
         assign shifted = {q[W-2:0], sin};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (op)
            OP_CLEAR: q <= '0;
            OP_SHIFT: q <= shifted;
            OP_FUNC:  if (load) q <= d;
            default:  q <= '0;
         endcase
      end
   end

   assign sout = q[W-1];

endmodule

// File: rtl/sg_prot_reg.sv
module sg_prot_reg
   import sg_pkg::*;
#(
   parameter int unsigned W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  sg_op_e       op,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (op)
            OP_CLEAR: q <= '0;
            OP_FUNC:  if (load) q <= d;
            OP_SHIFT: q <= q;
            default:  q <= '0;
         endcase
      end
   end

endmodule

// File: rtl/sscan_guard.sv
module sscan_guard
   import sg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned ST_W     = 3
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scan_en,
   input  logic                         scan_in,
   input  logic [NUM_REGS*DATA_W-1:0]   func_data,
   input  logic [NUM_REGS-1:0]          func_load,
   input  logic [KEY_W-1:0]             key_data,
   input  logic                         key_load,
   input  logic [ST_W-1:0]              state_next,
   input  logic                         state_load,
   output logic                         scan_out,
   output logic [NUM_REGS*DATA_W-1:0]   reg_q,
   output logic [KEY_W-1:0]             key_q,
   output logic [ST_W-1:0]              state_q,
   output logic                         clr_pulse
);

   localparam int unsigned CHAIN_W = sg_chain_len(NUM_REGS, DATA_W);

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("sscan_guard: NUM_REGS must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sscan_guard: DATA_W must be at least 1");
      end
      if (KEY_W < 1 || ST_W < 1) begin : g_bad_prot
         $error("sscan_guard: KEY_W and ST_W must be at least 1");
      end
      if (CHAIN_W != NUM_REGS * DATA_W) begin : g_bad_len
         $error("sscan_guard: chain length mismatch");
      end
   endgenerate

   sg_op_e op;
   logic   clr;

   sg_mode_track u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .op      (op),
      .clr     (clr)
   );

   // link[i] feeds segment i; link[NUM_REGS] is the chain end.
   logic [NUM_REGS:0] link;
   assign link[0] = scan_in;

   generate
      for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_seg
         sg_chain_seg #(.W(DATA_W)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op),
            .load  (func_load[gi]),
            .d     (func_data[gi*DATA_W +: DATA_W]),
            .sin   (link[gi]),
            .q     (reg_q[gi*DATA_W +: DATA_W]),
            .sout  (link[gi+1])
         );
      end
   endgenerate

   sg_prot_reg #(.W(KEY_W)) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .load  (key_load),
      .d     (key_data),
      .q     (key_q)
   );

   sg_prot_reg #(.W(ST_W)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .load  (state_load),
      .d     (state_next),
      .q     (state_q)
   );

   assign scan_out  = (op == OP_SHIFT) ? link[NUM_REGS] : 1'b0;
   assign clr_pulse = clr;

endmodule

// File: rtl/sscan_guard_chk.sv
module sscan_guard_chk #(
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned ST_W     = 3
)(
   input logic                         clk,
   input logic                         rst_n,
   input logic                         scan_en,
   input logic                         scan_in,
   input logic [NUM_REGS*DATA_W-1:0]   func_data,
   input logic [NUM_REGS-1:0]          func_load,
   input logic [KEY_W-1:0]             key_data,
   input logic                         key_load,
   input logic [ST_W-1:0]              state_next,
   input logic                         state_load,
   input logic                         scan_out,
   input logic [NUM_REGS*DATA_W-1:0]   reg_q,
   input logic [KEY_W-1:0]             key_q,
   input logic [ST_W-1:0]              state_q,
   input logic                         clr_pulse
);

   logic en_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_seen_q <= 1'b0;
      else        en_seen_q <= scan_en;
   end

   AST_CLR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en != en_seen_q) |-> clr_pulse); // R4

   AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en == en_seen_q) |-> !clr_pulse); // R4

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (reg_q == '0 && key_q == '0 && state_q == '0)); // R5

   AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en || clr_pulse) |-> !scan_out); // R6

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && !clr_pulse) |=> (reg_q[0] == $past(scan_in))); // R3

   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && !clr_pulse) |=> ($stable(key_q) && $stable(state_q))); // R7

   AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en && !clr_pulse && func_load[0])
      |=> (reg_q[DATA_W-1:0] == $past(func_data[DATA_W-1:0]))); // R2

endmodule

bind sscan_guard sscan_guard_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .KEY_W    (KEY_W),
   .ST_W     (ST_W)
) u_chk (.*);

// File: tb/sscan_guard_bench.sv
module sscan_guard_bench;

   localparam int NUM_REGS = 3;
   localparam int DATA_W   = 4;
   localparam int KEY_W    = 8;
   localparam int ST_W     = 3;
   localparam int CHAIN_W  = NUM_REGS * DATA_W;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  scan_en = 1'b0;
   logic                  scan_in = 1'b0;
   logic [CHAIN_W-1:0]    func_data = '0;
   logic [NUM_REGS-1:0]   func_load = '0;
   logic [KEY_W-1:0]      key_data = '0;
   logic                  key_load = 1'b0;
   logic [ST_W-1:0]       state_next = '0;
   logic                  state_load = 1'b0;
   logic                  scan_out;
   logic [CHAIN_W-1:0]    reg_q;
   logic [KEY_W-1:0]      key_q;
   logic [ST_W-1:0]       state_q;
   logic                  clr_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sscan_guard #(
      .NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .KEY_W (KEY_W), .ST_W (ST_W)
   ) u_sscan_guard (
      .clk (clk), .rst_n (rst_n), .scan_en (scan_en), .scan_in (scan_in),
      .func_data (func_data), .func_load (func_load),
      .key_data (key_data), .key_load (key_load),
      .state_next (state_next), .state_load (state_load),
      .scan_out (scan_out), .reg_q (reg_q), .key_q (key_q),
      .state_q (state_q), .clr_pulse (clr_pulse)
   );

   // Behavioural reference: chain as a bit queue, index 0 = entry bit.
   bit             m_chain[$];
   bit [KEY_W-1:0] m_key;
   bit [ST_W-1:0]  m_state;
   bit             m_prev;

   function automatic logic [CHAIN_W-1:0] m_pack();
      logic [CHAIN_W-1:0] v;
      for (int i = 0; i < CHAIN_W; i++) v[i] = m_chain[i];
      return v;
   endfunction

   function automatic bit m_clr();
      return scan_en != m_prev;
   endfunction

   function automatic bit m_out();
      return (scan_en && !m_clr()) ? m_chain[CHAIN_W-1] : 1'b0;
   endfunction

   task automatic m_reset();
      m_chain.delete();
      for (int i = 0; i < CHAIN_W; i++) m_chain.push_back(1'b0);
      m_key = '0; m_state = '0; m_prev = 1'b0;
   endtask

   task automatic m_edge();
      if (m_clr()) begin
         for (int i = 0; i < CHAIN_W; i++) m_chain[i] = 1'b0;
         m_key = '0; m_state = '0;
      end else if (scan_en) begin
         m_chain.push_front(scan_in);
         void'(m_chain.pop_back());
      end else begin
         for (int r = 0; r < NUM_REGS; r++)
            if (func_load[r])
               for (int b = 0; b < DATA_W; b++)
                  m_chain[r*DATA_W + b] = func_data[r*DATA_W + b];
         if (key_load)   m_key   = key_data;
         if (state_load) m_state = state_next;
      end
      m_prev = scan_en;
   endtask

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      check("R4 clr_pulse", 64'(clr_pulse), 64'(m_clr()));
      check("R6 scan_out",  64'(scan_out),  64'(m_out()));
      check("R3 reg_q",     64'(reg_q),     64'(m_pack()));
      check("R7 key_q",     64'(key_q),     64'(m_key));
      check("R7 state_q",   64'(state_q),   64'(m_state));
   endtask

   // Inputs change at the falling edge; compare 2 ns later, before the rise.
   task automatic tick();
      #2;
      check_all();
      @(posedge clk);
      m_edge();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      scan_in = 1'b0; func_load = '0; key_load = 1'b0; state_load = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lat;
      m_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reg_q reset", 64'(reg_q), 64'd0);
      check("R1 key_q reset", 64'(key_q), 64'd0);
      check("R1 scan_out reset", 64'(scan_out), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 clr_pulse after reset", 64'(clr_pulse), 64'd0);
      check("R1 state_q after reset", 64'(state_q), 64'd0);

      // R2, R7: functional loads
      for (int c = 0; c < 40; c++) begin
         func_data  = CHAIN_W'($urandom);
         func_load  = NUM_REGS'($urandom);
         key_data   = KEY_W'($urandom);
         key_load   = 1'($urandom);
         state_next = ST_W'($urandom);
         state_load = 1'($urandom);
         tick();
      end
      // Fill key with ones before entering test (R8)
      key_data = '1; key_load = 1'b1; state_next = '1; state_load = 1'b1;
      func_data = '1; func_load = '1;
      tick();
      check("R2 reg_q loaded all ones", 64'(reg_q), 64'((CHAIN_W)'('1)));
      check("R7 key_q loaded", 64'(key_q), 64'((KEY_W)'('1)));

      // R4/R5: entry to test clears
      idle_inputs();
      scan_en = 1'b1;
      #2;
      check("R4 clr on rise", 64'(clr_pulse), 64'd1);
      check("R6 scan_out low in clear", 64'(scan_out), 64'd0);
      #0; @(posedge clk); m_edge(); @(negedge clk);
      check("R5 chain zero after entry", 64'(reg_q), 64'd0);
      check("R5 key zero after entry", 64'(key_q), 64'd0);
      check("R5 state zero after entry", 64'(state_q), 64'd0);

      // R3: marker latency; R7: load strobes during shift ignored
      lat = -1;
      for (int k = 0; k < 2 * CHAIN_W; k++) begin
         scan_in    = (k == 0);
         key_load   = 1'b1; key_data = 8'hA5;
         state_load = 1'b1; state_next = 3'b101;
         #1;
         if (scan_out && lat < 0) lat = k;
         tick();
      end
      check("R3 chain length", 64'(lat), 64'(CHAIN_W));
      check("R7 key held in shift", 64'(key_q), 64'd0);
      check("R8 state held in shift", 64'(state_q), 64'd0);

      // R8: long zero run after a key of ones never yields a 1
      idle_inputs();
      scan_en = 1'b0; tick(); tick();
      key_data = '1; key_load = 1'b1; tick();
      idle_inputs();
      scan_en = 1'b1;
      lat = 0;
      for (int k = 0; k < 3 * CHAIN_W; k++) begin
         #1;
         if (scan_out) lat++;
         tick();
      end
      check("R8 no key bits at scan_out", 64'(lat), 64'd0);

      // R4/R5: exit from test with pattern in chain
      for (int k = 0; k < CHAIN_W; k++) begin
         scan_in = 1'b1;
         tick();
      end
      check("R3 chain all ones", 64'(reg_q), 64'((CHAIN_W)'('1)));
      idle_inputs();
      func_load = '1; func_data = '1;
      scan_en = 1'b0;
      #2;
      check("R4 clr on fall", 64'(clr_pulse), 64'd1);
      @(posedge clk); m_edge(); @(negedge clk);
      check("R5 chain zero after exit", 64'(reg_q), 64'd0);
      idle_inputs();

      // Mixed random operation
      for (int c = 0; c < 600; c++) begin
         if (($urandom % 13) == 0) scan_en = ~scan_en;
         scan_in    = 1'($urandom);
         func_data  = CHAIN_W'($urandom);
         func_load  = NUM_REGS'($urandom);
         key_data   = KEY_W'($urandom);
         key_load   = 1'($urandom);
         state_next = ST_W'($urandom);
         state_load = 1'($urandom);
         tick();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule